// File: doc/BRIEF.md
# Address Translation Cache with Protection

This block turns a 32-bit logical address into a physical address inside the same cycle as the access request. It holds a small fully associative set of page translations with 4 KB pages. Every entry is compared against the request in parallel, so a resident translation costs no extra cycle. When a lookup succeeds, the block also checks the page's write-protect and supervisor-only attributes, drives a per-page cache-inhibit flag, and reports when a write lands on a page whose modified history bit is still clear, so that the page descriptor can be updated.

Some accesses skip translation altogether. A global disable input passes every address through unchanged. Two programmable windows, matched on the upper address byte under a don't-care mask, do the same for the addresses they cover. A configurable count of upper logical bits, from 0 to 15, is excluded from the tag comparison. A miss or a protection violation raises abort combinationally, early enough to stop the external bus strobe. A miss also raises a fill request. An external walker answers it through the fill port. A flush input invalidates the whole table at once.

Top module: `xlat_cache`

## Requirements
- R1: On a request that matches a valid entry and passes protection, `rsp_paddr` = {entry physical page, `req_laddr[11:0]`}, `rsp_hit`=1 and `rsp_abort`=0, all in the same cycle as the request.
- R2: On a request that matches no valid entry and is not bypassed, `rsp_abort`=1, `rsp_fill_req`=1, `rsp_hit`=0 and `rsp_paddr`=0.
- R3: A write to a write-protected page, or a request with `req_super`=0 to a supervisor-only page, gives `rsp_hit`=1, `rsp_abort`=1, `rsp_fill_req`=0 and `rsp_paddr`=0.
- R4: While `xlat_off`=1, a valid request gives `rsp_paddr`=`req_laddr`, `rsp_hit`=1, and `rsp_abort`, `rsp_cinh` and `rsp_fill_req` all 0, whatever the table holds and whatever the protection bits are.
- R5: Window w matches when its enable bit is set and (`req_laddr[31:24]` XOR base) AND NOT mask is zero, where a mask bit of 1 means don't care. A matching request behaves as in R4. Window matching takes priority over the table.
- R6: With an initial-shift count of N, the top N bits of the logical address (and of stored tags) are left out of the tag comparison.
- R7: `rsp_cinh` equals the matched entry's cache-inhibit bit on a permitted hit, and is 0 in every other case.
- R8: A config write takes effect only when `cfg_super`=1. `cfg_sel`=0 or 1 writes window 0 or 1 from `cfg_wdata[31:24]` (base), `[23:16]` (mask) and `[0]` (enable). `cfg_sel`=2 writes the shift count from `cfg_wdata[3:0]`.
- R9: A permitted write hit on an entry whose modified bit is clear raises `rsp_hist_upd` in that cycle. The entry's modified bit is then set, so a later write to the same page does not raise it. Reads never raise it.
- R10: A fill goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry named by a round-robin pointer, which starts at 0, advances by one for each such fill and wraps after the last entry. Flush does not move the pointer.
- R11: A one-cycle `flush` invalidates every entry by the next cycle. A fill in the same cycle as a flush is dropped.
- R12: With `req_valid`=0, all result outputs are 0.
- R13: After reset, every entry is invalid, both windows are disabled and the shift count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_laddr | input | 32 | Logical address |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor access |
| xlat_off | input | 1 | Global translation disable |
| fill_en | input | 1 | Load one entry |
| fill_lpage | input | 20 | Logical page of the new entry |
| fill_ppage | input | 20 | Physical page of the new entry |
| fill_wprot | input | 1 | Write-protect attribute |
| fill_sonly | input | 1 | Supervisor-only attribute |
| fill_cinh | input | 1 | Cache-inhibit attribute |
| fill_dirty | input | 1 | Initial modified bit |
| flush | input | 1 | Invalidate all entries |
| cfg_we | input | 1 | Config register write strobe |
| cfg_super | input | 1 | Privilege of the config write |
| cfg_sel | input | 2 | Register select: 0/1 window, 2 shift |
| cfg_wdata | input | 32 | Config write data |
| rsp_paddr | output | 32 | Physical address |
| rsp_hit | output | 1 | Translation found or bypassed |
| rsp_abort | output | 1 | Suppress the bus cycle |
| rsp_cinh | output | 1 | Cache inhibit for this access |
| rsp_fill_req | output | 1 | Miss; translation needs loading |
| rsp_hist_upd | output | 1 | Descriptor modified bit needs setting |

## Verification
On every cycle, the assertions check these cross-output rules: a fill request always comes with abort and without hit; an aborted access never exposes a physical address; the disable input never lets an abort through; a history update only appears on an unaborted write hit; an idle request port keeps all results low. In the state-holding blocks, they check that a flush empties the table by the next edge and that an unprivileged config write leaves every configuration field unchanged. Only the directed scenarios can show the actual address arithmetic, the window mask decode, the shift-count aliasing, the victim order of the round-robin replacement, and that the modified bit stops a second history request.

// File: rtl/xc_pkg.sv
package xc_pkg;
    localparam int ADDR_W  = 32;
    localparam int PAGE_W  = 12;
    localparam int VPN_W   = ADDR_W - PAGE_W;
    localparam int SHIFT_W = 4;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] ppn;
        logic             wprot;
        logic             sonly;
        logic             cinh;
        logic             dirty;
    } xc_entry_t;
endpackage

// File: rtl/xc_cfg_regs.sv
module xc_cfg_regs
    import xc_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = 8,
    localparam int SEL_W  = $clog2(NUM_WIN + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic                          cfg_super,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output logic [NUM_WIN-1:0][WIN_W-1:0] win_base,
    output logic [NUM_WIN-1:0][WIN_W-1:0] win_mask,
    output logic [NUM_WIN-1:0]            win_en,
    output logic [SHIFT_W-1:0]            shift
);
    typedef struct packed {
        logic [NUM_WIN-1:0][WIN_W-1:0] base;
        logic [NUM_WIN-1:0][WIN_W-1:0] mask;
        logic [NUM_WIN-1:0]            en;
        logic [SHIFT_W-1:0]            shift;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && cfg_super) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (cfg_sel == SEL_W'(w)) begin
                    st_d.base[w] = cfg_wdata[ADDR_W-1 -: WIN_W];
                    st_d.mask[w] = cfg_wdata[ADDR_W-WIN_W-1 -: WIN_W];
                    st_d.en[w]   = cfg_wdata[0];
                end
            end
            if (cfg_sel == SEL_W'(NUM_WIN)) begin
                st_d.shift = cfg_wdata[SHIFT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_base = st_q.base;
    assign win_mask = st_q.mask;
    assign win_en   = st_q.en;
    assign shift    = st_q.shift;

    // R8
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_super) |=> $stable(st_q));
endmodule

// File: rtl/xc_window.sv
module xc_window #(
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = 8,
    parameter int ADDR_W  = 32
) (
    input  logic [ADDR_W-1:0]             laddr,
    input  logic [NUM_WIN-1:0][WIN_W-1:0] win_base,
    input  logic [NUM_WIN-1:0][WIN_W-1:0] win_mask,
    input  logic [NUM_WIN-1:0]            win_en,
    output logic                          any_hit
);
    logic [NUM_WIN-1:0] hit_vec;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit_vec[w] = win_en[w] &&
            (((laddr[ADDR_W-1 -: WIN_W] ^ win_base[w]) & ~win_mask[w]) == '0);
    end

    assign any_hit = |hit_vec;
endmodule

// File: rtl/xc_tag_store.sv
module xc_tag_store
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  xc_entry_t        fill_ent,
    input  logic             flush,
    input  logic             dirty_set,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic [VPN_W-1:0] keep_mask,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output xc_entry_t        hit_ent
);
    typedef struct packed {
        xc_entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]        rr;
    } ts_state_t;

    ts_state_t st_d, st_q;

    logic [ENTRIES-1:0] match_vec;
    logic [ENTRIES-1:0] valid_vec;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   victim;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign valid_vec[g] = st_q.ent[g].valid;
        assign match_vec[g] = st_q.ent[g].valid &&
            (((st_q.ent[g].vpn ^ look_vpn) & keep_mask) == '0);
    end

    // lowest index wins, both for lookup and free-slot search
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!valid_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign hit_ent = st_q.ent[hit_idx];
    assign victim  = free_any ? free_idx : st_q.rr;

    always_comb begin
        st_d = st_q;
        if (dirty_set) begin
            st_d.ent[dirty_idx].dirty = 1'b1;
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].valid = 1'b0;
            end
        end else if (fill_en) begin
            st_d.ent[victim]       = fill_ent;
            st_d.ent[victim].valid = 1'b1;
            if (!free_any) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R10
    fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> ($countones(valid_vec) >= 1));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = 8,
    localparam int SEL_W  = $clog2(NUM_WIN + 1),
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic              req_write,
    input  logic              req_super,
    input  logic              xlat_off,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_lpage,
    input  logic [VPN_W-1:0]  fill_ppage,
    input  logic              fill_wprot,
    input  logic              fill_sonly,
    input  logic              fill_cinh,
    input  logic              fill_dirty,
    input  logic              flush,
    input  logic              cfg_we,
    input  logic              cfg_super,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_hit,
    output logic              rsp_abort,
    output logic              rsp_cinh,
    output logic              rsp_fill_req,
    output logic              rsp_hist_upd
);
    logic [NUM_WIN-1:0][WIN_W-1:0] win_base;
    logic [NUM_WIN-1:0][WIN_W-1:0] win_mask;
    logic [NUM_WIN-1:0]            win_en;
    logic [SHIFT_W-1:0]            shift;
    logic                          win_hit;
    logic [VPN_W-1:0]              keep_mask;
    logic                          c_hit;
    logic [IDX_W-1:0]              c_idx;
    xc_entry_t                     c_ent;
    xc_entry_t                     fill_ent;
    logic                          dirty_set;
    logic                          deny;

    xc_cfg_regs #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_super(cfg_super), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .win_base(win_base), .win_mask(win_mask), .win_en(win_en), .shift(shift)
    );

    xc_window #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W), .ADDR_W(ADDR_W)) u_win (
        .laddr(req_laddr), .win_base(win_base), .win_mask(win_mask),
        .win_en(win_en), .any_hit(win_hit)
    );

    // ignored upper bits are cleared from the comparison on both sides
    assign keep_mask = {VPN_W{1'b1}} >> shift;

    always_comb begin
        fill_ent       = '0;
        fill_ent.valid = 1'b1;
        fill_ent.vpn   = fill_lpage;
        fill_ent.ppn   = fill_ppage;
        fill_ent.wprot = fill_wprot;
        fill_ent.sonly = fill_sonly;
        fill_ent.cinh  = fill_cinh;
        fill_ent.dirty = fill_dirty;
    end

    xc_tag_store #(.ENTRIES(ENTRIES)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_ent(fill_ent), .flush(flush),
        .dirty_set(dirty_set), .dirty_idx(c_idx),
        .look_vpn(req_laddr[ADDR_W-1:PAGE_W]), .keep_mask(keep_mask),
        .hit(c_hit), .hit_idx(c_idx), .hit_ent(c_ent)
    );

    assign deny = (req_write && c_ent.wprot) || (!req_super && c_ent.sonly);

    always_comb begin
        rsp_paddr    = '0;
        rsp_hit      = 1'b0;
        rsp_abort    = 1'b0;
        rsp_cinh     = 1'b0;
        rsp_fill_req = 1'b0;
        rsp_hist_upd = 1'b0;
        dirty_set    = 1'b0;
        if (req_valid) begin
            if (xlat_off || win_hit) begin
                rsp_paddr = req_laddr;
                rsp_hit   = 1'b1;
            end else if (c_hit) begin
                rsp_hit = 1'b1;
                if (deny) begin
                    rsp_abort = 1'b1;
                end else begin
                    rsp_paddr = {c_ent.ppn, req_laddr[PAGE_W-1:0]};
                    rsp_cinh  = c_ent.cinh;
                    if (req_write && !c_ent.dirty) begin
                        rsp_hist_upd = 1'b1;
                        dirty_set    = 1'b1;
                    end
                end
            end else begin
                rsp_abort    = 1'b1;
                rsp_fill_req = 1'b1;
            end
        end
    end

    // R2
    fill_req_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fill_req |-> (rsp_abort && !rsp_hit));

    // R3
    abort_hides_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_abort |-> (rsp_paddr == '0 && !rsp_cinh));

    // R4
    disable_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && xlat_off) |-> (!rsp_abort && rsp_hit && rsp_paddr == req_laddr));

    // R9
    hist_on_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hist_upd |-> (req_write && rsp_hit && !rsp_abort));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !rsp_abort && !rsp_fill_req && !rsp_hist_upd));
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic        req_super = 1'b1;
    logic        xlat_off = 1'b0;
    logic        fill_en = 1'b0;
    logic [19:0] fill_lpage = '0;
    logic [19:0] fill_ppage = '0;
    logic        fill_wprot = 1'b0;
    logic        fill_sonly = 1'b0;
    logic        fill_cinh = 1'b0;
    logic        fill_dirty = 1'b0;
    logic        flush = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_super = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rsp_paddr;
    logic        rsp_hit, rsp_abort, rsp_cinh, rsp_fill_req, rsp_hist_upd;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
        .req_write(req_write), .req_super(req_super), .xlat_off(xlat_off),
        .fill_en(fill_en), .fill_lpage(fill_lpage), .fill_ppage(fill_ppage),
        .fill_wprot(fill_wprot), .fill_sonly(fill_sonly), .fill_cinh(fill_cinh),
        .fill_dirty(fill_dirty), .flush(flush), .cfg_we(cfg_we), .cfg_super(cfg_super),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rsp_paddr(rsp_paddr), .rsp_hit(rsp_hit),
        .rsp_abort(rsp_abort), .rsp_cinh(rsp_cinh), .rsp_fill_req(rsp_fill_req),
        .rsp_hist_upd(rsp_hist_upd)
    );

    // result bundle: {paddr, hit, abort, cinh, fill_req, hist_upd}
    function automatic logic [36:0] pack(logic [31:0] pa, logic h, logic a, logic c,
                                         logic f, logic u);
        return {pa, h, a, c, f, u};
    endfunction

    task automatic compare(string rq, logic [36:0] act, logic [36:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic fill(logic [19:0] lp, logic [19:0] pp, logic wp, logic so,
                        logic ci, logic dm);
        @(negedge clk);
        fill_en = 1'b1; fill_lpage = lp; fill_ppage = pp;
        fill_wprot = wp; fill_sonly = so; fill_cinh = ci; fill_dirty = dm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic cfg_write(logic sup, logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_super = sup; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic lookup(string rq, logic [31:0] la, logic wr, logic sup,
                          logic [36:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_laddr = la; req_write = wr; req_super = sup;
        #1;
        compare(rq, pack(rsp_paddr, rsp_hit, rsp_abort, rsp_cinh, rsp_fill_req,
                         rsp_hist_upd), exp);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    function automatic logic [36:0] miss();
        return pack(32'h0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    endfunction

    function automatic logic [36:0] denied();
        return pack(32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endfunction

    function automatic logic [36:0] pass(logic [31:0] la);
        return pack(la, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    endfunction

    task automatic t_reset();
        lookup("R13 empty table", 32'h0000_0000, 1'b0, 1'b1, miss());
        lookup("R13 window off", 32'h4A00_0000, 1'b0, 1'b1, miss());
    endtask

    task automatic t_hit_miss();
        fill(20'h00010, 20'h0ABCD, 1'b0, 1'b0, 1'b0, 1'b1);
        lookup("R1 hit", 32'h0001_0123, 1'b0, 1'b1,
               pack(32'h0ABC_D123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        lookup("R2 miss", 32'h0002_0123, 1'b0, 1'b1, miss());
    endtask

    task automatic t_protect();
        fill(20'h00030, 20'h00333, 1'b1, 1'b0, 1'b0, 1'b1);
        fill(20'h00040, 20'h00444, 1'b0, 1'b1, 1'b1, 1'b1);
        lookup("R3 write protected", 32'h0003_0004, 1'b1, 1'b1, denied());
        lookup("R3 read of wp page", 32'h0003_0004, 1'b0, 1'b0,
               pack(32'h0033_3004, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        lookup("R3 user to super page", 32'h0004_0008, 1'b0, 1'b0, denied());
        lookup("R7 cinh on hit", 32'h0004_0008, 1'b0, 1'b1,
               pack(32'h0044_4008, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
    endtask

    task automatic t_disable();
        xlat_off = 1'b1;
        lookup("R4 bypass protected", 32'h0003_0004, 1'b1, 1'b0, pass(32'h0003_0004));
        lookup("R4 bypass miss", 32'h0009_9000, 1'b0, 1'b1, pass(32'h0009_9000));
        lookup("R4 bypass cinh page", 32'h0004_0008, 1'b0, 1'b1, pass(32'h0004_0008));
        xlat_off = 1'b0;
    endtask

    task automatic t_window();
        cfg_write(1'b1, 2'd0, {8'h40, 8'h0F, 15'd0, 1'b1});
        lookup("R5 win0 masked match", 32'h4A00_1000, 1'b0, 1'b1, pass(32'h4A00_1000));
        lookup("R5 win0 no match", 32'h5000_1000, 1'b0, 1'b1, miss());
        cfg_write(1'b1, 2'd1, {8'h80, 8'h00, 15'd0, 1'b1});
        lookup("R5 win1 exact", 32'h8000_0004, 1'b1, 1'b0, pass(32'h8000_0004));
        lookup("R5 win1 miss", 32'h8100_0004, 1'b0, 1'b1, miss());
        fill(20'h4A001, 20'h11111, 1'b0, 1'b1, 1'b1, 1'b1);
        lookup("R5 window over table", 32'h4A00_1234, 1'b0, 1'b0, pass(32'h4A00_1234));
        cfg_write(1'b1, 2'd0, 32'h0);
        cfg_write(1'b1, 2'd1, 32'h0);
        lookup("R5 disabled window", 32'h4A00_1234, 1'b0, 1'b0, denied());
    endtask

    task automatic t_shift();
        lookup("R6 shift 0 keeps upper", 32'hF001_0123, 1'b0, 1'b1, miss());
        cfg_write(1'b1, 2'd2, 32'h4);
        lookup("R6 shift 4 ignores upper", 32'hF001_0123, 1'b0, 1'b1,
               pack(32'h0ABC_D123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        lookup("R6 bit below shift counts", 32'hF801_0123, 1'b0, 1'b1, miss());
        cfg_write(1'b1, 2'd2, 32'h0);
    endtask

    task automatic t_cfg_user();
        cfg_write(1'b0, 2'd2, 32'h4);
        lookup("R8 user shift write ignored", 32'hF001_0123, 1'b0, 1'b1, miss());
        cfg_write(1'b0, 2'd1, {8'hF0, 8'h00, 15'd0, 1'b1});
        lookup("R8 user window write ignored", 32'hF001_0123, 1'b0, 1'b1, miss());
    endtask

    task automatic t_history();
        fill(20'h00050, 20'h00555, 1'b0, 1'b0, 1'b0, 1'b0);
        fill(20'h00060, 20'h00666, 1'b0, 1'b0, 1'b0, 1'b0);
        lookup("R9 first write", 32'h0005_0010, 1'b1, 1'b1,
               pack(32'h0055_5010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
        lookup("R9 second write", 32'h0005_0010, 1'b1, 1'b1,
               pack(32'h0055_5010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        lookup("R9 read clean page", 32'h0006_0020, 1'b0, 1'b1,
               pack(32'h0066_6020, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    endtask

    task automatic t_replace();
        do_flush();
        for (int i = 0; i < 8; i++) begin
            fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b0, 1'b0, 1'b0, 1'b1);
        end
        for (int i = 0; i < 8; i++) begin
            lookup("R10 all eight resident", {20'h00100 + 20'(i), 12'h0}, 1'b0, 1'b1,
                   pass({20'h00200 + 20'(i), 12'h0}));
        end
        fill(20'h00108, 20'h00308, 1'b0, 1'b0, 1'b0, 1'b1);
        lookup("R10 slot 0 evicted", 32'h0010_0000, 1'b0, 1'b1, miss());
        lookup("R10 slot 1 kept", 32'h0010_1000, 1'b0, 1'b1, pass(32'h0020_1000));
        lookup("R10 new entry", 32'h0010_8abc, 1'b0, 1'b1, pass(32'h0030_8abc));
        fill(20'h00109, 20'h00309, 1'b0, 1'b0, 1'b0, 1'b1);
        lookup("R10 slot 1 evicted next", 32'h0010_1000, 1'b0, 1'b1, miss());
        lookup("R10 slot 2 kept", 32'h0010_2000, 1'b0, 1'b1, pass(32'h0020_2000));
    endtask

    task automatic t_flush();
        do_flush();
        lookup("R11 flushed", 32'h0010_2000, 1'b0, 1'b1, miss());
        @(negedge clk);
        flush = 1'b1; fill_en = 1'b1; fill_lpage = 20'h00700; fill_ppage = 20'h00777;
        fill_wprot = 1'b0; fill_sonly = 1'b0; fill_cinh = 1'b0; fill_dirty = 1'b1;
        @(negedge clk);
        flush = 1'b0; fill_en = 1'b0;
        lookup("R11 fill dropped under flush", 32'h0070_0000, 1'b0, 1'b1, miss());
    endtask

    task automatic t_idle();
        fill(20'h00800, 20'h00888, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        req_valid = 1'b0; req_laddr = 32'h0080_0000; req_write = 1'b1;
        #1;
        compare("R12 idle on resident page", pack(rsp_paddr, rsp_hit, rsp_abort, rsp_cinh,
                rsp_fill_req, rsp_hist_upd), '0);
        xlat_off = 1'b1;
        #1;
        compare("R12 idle with disable", pack(rsp_paddr, rsp_hit, rsp_abort, rsp_cinh,
                rsp_fill_req, rsp_hist_upd), '0);
        xlat_off = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hit_miss();
        t_protect();
        t_disable();
        t_window();
        t_shift();
        t_cfg_user();
        t_history();
        t_replace();
        t_flush();
        t_idle();
        finish_run();
    end
endmodule